// File: doc/BRIEF.md
# Bridge Configuration Register Space

This block holds the configuration registers of a bridge root port as a flat register file. Each bit has a fixed access kind: read-only, read-write, write-one-to-clear, or reserved. The kind is chosen per bit and per dword. A 64-byte standard header is always present. When the `HAS_CAP` parameter is set, a 60-byte express capability region follows directly after it, starting at byte 0x40. Setting `HAS_CAP` also turns a set of legacy-only header bits into reserved bits. The `NO_PREF` parameter removes the prefetchable window, so its base/limit dword can no longer be written.

Software reaches the registers through a one-cycle access port. The port takes a byte address, an access size of 1, 2 or 4 bytes, a read or write strobe, and right-justified write data. It returns registered read data and an error flag. Surrounding hardware reports conditions through an event port. An event names a dword index and a bit vector, and it raises any write-one-to-clear bits of that dword that are set in the vector.

Top module: `bridge_cfg_space`

## Requirements
- R1: Bits that are not read-only, read-write or write-one-to-clear always read as 0, whatever was written or signalled to them.
- R2: Accesses at or beyond the end of the implemented space read 0, and writes there are dropped. The space ends at byte 0x40, or at 0x7C when `HAS_CAP`=1.
- R3: A 1-byte or 2-byte read returns the aligned dword shifted right by 8×addr[1:0], masked to 8 or 16 bits. A 4-byte read returns the whole aligned dword.
- R4: An access size other than 1, 2 or 4 sets `rsp_err` in the next cycle. Such a read returns 0 and such a write changes nothing. A valid access leaves `rsp_err` low.
- R5: A write builds a lane mask: all ones for size 4, otherwise 0xFF or 0xFFFF shifted left by 8×addr[1:0], with the data shifted the same way. Read-write bits inside the mask take the new value. Read-only bits never change.
- R6: Write-one-to-clear bits inside the lane mask clear where a 1 is written. Everything else keeps its value.
- R7: In dword 1 (0x04), command bits 0, 1, 2, 6 and 8 are read-write, status bits 31, 30, 29, 28, 27 and 24 are write-one-to-clear, and bit 20 (capability list) resets to 1.
- R8: Bus number bits 23:0 at 0x18 are read-write and bits 31:24 read 0. The memory window (0x20) and prefetchable window (0x24) have bits 31:20 and 15:4 read-write. With `NO_PREF`=1, 0x24 has no writable bits.
- R9: After reset, the registers read as follows:

  | Address | Value |
  |---|---|
  | 0x00 | `ID_WORD` |
  | 0x08 | {16'h0604, 8'h00, `REV`} |
  | 0x0C | 0x0001_0010 |
  | 0x04 | 0x0010_0000 |
  | 0x34 | 0x40 with `HAS_CAP`, 0 without |
  | 0x40 | 0x0040_0010 (capability ID 0x10, port type 4 in bits 23:20) |
- R10: With `HAS_CAP`=1, bridge-control bits 21, 24, 25 and 27 at 0x3C become reserved, and bit 26 is no longer write-one-to-clear. Without it, bits 31:16 mask 0x0B6F are read-write and bit 26 is write-one-to-clear. Bits 7:0 of 0x3C are read-write in both cases.
- R11: In the capability region, at 0x50, bits 15:14, 11:9, 7:3 and 1:0 are read-write, and bits 31:30 are write-one-to-clear. At 0x60, bit 16 is write-one-to-clear and bit 17 is read-only.
- R12: An event sets those write-one-to-clear bits of dword `ev_idx` that are 1 in `ev_bits`, and no others. When an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R13: Read data appears in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Access size in bytes (1, 2, 4 valid) |
| req_wdata | input | 32 | Right-justified write data |
| ev_valid | input | 1 | Event strobe |
| ev_idx | input | ADDR_W-2 | Dword index the event targets |
| ev_bits | input | 32 | Bits to raise in that dword |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Registered bad-size flag |

## Verification
Two functions can fall in the same cycle: a hardware event that raises a status bit, and a software write-one-to-clear that clears that same bit. The bench provokes this by asserting the event and a byte write on one clock edge, to the status byte of dword 1. A later read must show the contested bit still set, while a neighbouring bit cleared by the same write must be 0. A second collision is tested in the same way in the link status of the capability region.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;

  typedef struct packed {
    logic [31:0] ro;
    logic [31:0] rw;
    logic [31:0] w1c;
  } bit_kind_t;

  localparam int HDR_DWORDS = 16;
  localparam int CAP_DWORDS = 15;

  // Per-dword access kinds; bits absent from all three masks are reserved.
  function automatic bit_kind_t reg_kind(input int idx, input bit cap_en,
                                         input bit no_pref);
    bit_kind_t k;
    k = '0;
    if (idx < HDR_DWORDS) begin
      case (idx)
        0, 2, 4, 5, 14: k.ro = 32'hFFFF_FFFF;
        1: begin
          k.rw  = 32'h0000_0147;
          k.w1c = 32'hF900_0000;
          k.ro  = cap_en ? 32'h0010_0000 : 32'h06B0_02B8;
        end
        3: k.ro = cap_en ? 32'hFFFF_00FF : 32'hFFFF_FFFF;
        6: begin
          k.rw = 32'h00FF_FFFF;
          k.ro = cap_en ? 32'h0000_0000 : 32'hFF00_0000;
        end
        7: begin
          k.rw  = 32'h0000_F0F0;
          k.w1c = 32'hF900_0000;
          k.ro  = cap_en ? 32'h0000_0F0F : 32'h06A0_0F0F;
        end
        8: begin
          k.rw = 32'hFFF0_FFF0;
          k.ro = 32'h000F_000F;
        end
        9: begin
          k.rw = no_pref ? 32'h0 : 32'hFFF0_FFF0;
          k.ro = no_pref ? 32'hFFFF_FFFF : 32'h000F_000F;
        end
        10, 11, 12: k.rw = 32'hFFFF_FFFF;
        13: k.ro = 32'h0000_00FF;
        15: begin
          k.rw  = cap_en ? 32'h004F_00FF : 32'h0B6F_00FF;
          k.ro  = cap_en ? 32'h0000_FF00 : 32'h0080_FF00;
          k.w1c = cap_en ? 32'h0 : 32'h0400_0000;
        end
        default: k = '0;
      endcase
    end else begin
      case (idx - HDR_DWORDS)
        0: k.ro = 32'h7FFF_FFFF;
        1: k.ro = 32'h0000_803F;
        2: begin
          k.rw  = 32'h0000_7FFF;
          k.w1c = 32'h000F_0000;
          k.ro  = 32'h0030_0000;
        end
        3: k.ro = 32'hFF7B_FFFF;
        4: begin
          k.rw  = 32'h0000_CEFB;
          k.ro  = 32'h3FFF_0000;
          k.w1c = 32'hC000_0000;
        end
        5: k.ro = 32'hFFFF_FFFF;
        6: begin
          k.rw  = 32'h0000_7FFF;
          k.w1c = 32'h011F_0000;
          k.ro  = 32'h00E0_0000;
        end
        7: begin
          k.rw = 32'h0000_001F;
          k.ro = 32'h0001_0000;
        end
        8: begin
          k.ro  = 32'h0002_FFFF;
          k.w1c = 32'h0001_0000;
        end
        default: k = '0;
      endcase
    end
    return k;
  endfunction

  function automatic logic [31:0] reg_init(input int idx, input bit cap_en,
                                           input logic [31:0] id_word,
                                           input logic [7:0] rev);
    case (idx)
      0:  return id_word;
      1:  return 32'h0010_0000;
      2:  return {16'h0604, 8'h00, rev};
      3:  return 32'h0001_0010;
      13: return cap_en ? 32'h0000_0040 : 32'h0;
      16: return 32'h0040_0010;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/bridge_cfg_lanes.sv
module bridge_cfg_lanes (
  input  logic [1:0]  addr_lo,
  input  logic [2:0]  size,
  input  logic [31:0] data_in,
  output logic        size_ok,
  output logic [31:0] lane_mask,
  output logic [31:0] lane_data
);
  logic [4:0] sh;
  assign sh = {addr_lo, 3'b000};

  always_comb begin
    size_ok   = 1'b1;
    lane_mask = 32'h0;
    lane_data = data_in << sh;
    case (size)
      3'd1: lane_mask = 32'h0000_00FF << sh;
      3'd2: lane_mask = 32'h0000_FFFF << sh;
      3'd4: begin
        lane_mask = 32'hFFFF_FFFF;
        lane_data = data_in;
      end
      default: size_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/bridge_cfg_word.sv
module bridge_cfg_word #(
  parameter logic [31:0] RO_M  = 32'h0,
  parameter logic [31:0] RW_M  = 32'h0,
  parameter logic [31:0] W1C_M = 32'h0,
  parameter logic [31:0] INIT  = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wmask,
  input  logic [31:0] wdata,
  input  logic [31:0] ev_set,
  output logic [31:0] q
);
  localparam logic [31:0] HELD = RW_M | W1C_M;

  logic [31:0] store_q, store_d;
  logic        upd;

  always_comb begin
    store_d = store_q;
    if (we) begin
      store_d = (store_d & ~(RW_M & wmask)) | (wdata & RW_M & wmask);
      store_d = store_d & ~(wdata & W1C_M & wmask);
    end
    // hardware set after software clear: the event survives a collision
    store_d = (store_d | (ev_set & W1C_M)) & HELD;
  end

  assign upd = we | (|ev_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   store_q <= INIT & HELD;
    else if (upd) store_q <= store_d;
  end

  assign q = (store_q & HELD) | (INIT & RO_M);
endmodule

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space #(
  parameter bit          HAS_CAP = 1'b1,
  parameter bit          NO_PREF = 1'b0,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] ID_WORD = 32'hC0DE_1AB5,
  parameter logic [7:0]  REV     = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              ev_valid,
  input  logic [ADDR_W-3:0] ev_idx,
  input  logic [31:0]       ev_bits,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  import bridge_cfg_pkg::*;

  localparam int NDW = HAS_CAP ? (HDR_DWORDS + CAP_DWORDS) : HDR_DWORDS;
  localparam int IW  = ADDR_W - 2;

  logic [IW-1:0] idx;
  logic          in_rng, size_ok, wr_en;
  logic [31:0]   lane_mask, lane_data;
  logic [31:0]   words [NDW];
  logic [31:0]   rd_word, rd_fmt, rdata_d;
  logic          err_d;

  assign idx    = req_addr[ADDR_W-1:2];
  assign in_rng = (int'(idx) < NDW);
  assign wr_en  = req_wr & size_ok & in_rng;

  bridge_cfg_lanes u_lanes (
    .addr_lo  (req_addr[1:0]),
    .size     (req_size),
    .data_in  (req_wdata),
    .size_ok  (size_ok),
    .lane_mask(lane_mask),
    .lane_data(lane_data)
  );

  for (genvar g = 0; g < NDW; g++) begin : g_word
    localparam bit_kind_t KIND = reg_kind(g, HAS_CAP, NO_PREF);
    logic        hit_wr;
    logic [31:0] ev_set;
    assign hit_wr = wr_en & (int'(idx) == g);
    assign ev_set = (ev_valid && int'(ev_idx) == g) ? ev_bits : 32'h0;
    bridge_cfg_word #(
      .RO_M (KIND.ro),
      .RW_M (KIND.rw),
      .W1C_M(KIND.w1c),
      .INIT (reg_init(g, HAS_CAP, ID_WORD, REV))
    ) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (hit_wr),
      .wmask (lane_mask),
      .wdata (lane_data),
      .ev_set(ev_set),
      .q     (words[g])
    );
  end

  always_comb begin
    rd_word = 32'h0;
    for (int i = 0; i < NDW; i++)
      if (int'(idx) == i) rd_word = words[i];
  end

  always_comb begin
    rd_fmt = rd_word >> {req_addr[1:0], 3'b000};
    case (req_size)
      3'd1:    rdata_d = rd_fmt & 32'h0000_00FF;
      3'd2:    rdata_d = rd_fmt & 32'h0000_FFFF;
      3'd4:    rdata_d = rd_word;
      default: rdata_d = 32'h0;
    endcase
    err_d = (req_rd | req_wr) & ~size_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= 32'h0;
      rsp_err   <= 1'b0;
    end else begin
      if (req_rd) rsp_rdata <= rdata_d;
      rsp_err <= err_d;
    end
  end
endmodule

// File: rtl/bridge_cfg_space_chk.sv
module bridge_cfg_space_chk #(
  parameter bit HAS_CAP = 1'b1,
  parameter int ADDR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_rd,
  input logic              req_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_size,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err
);
  localparam int END_BYTE = HAS_CAP ? 32'h7C : 32'h40;

  logic ok_sz;
  assign ok_sz = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

  a_r2_beyond_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && ok_sz && int'(req_addr) >= END_BYTE) |=> (rsp_rdata == 32'h0));

  a_r3_byte_read_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && req_size == 3'd1) |=> (rsp_rdata[31:8] == 24'h0));

  a_r3_half_read_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && req_size == 3'd2) |=> (rsp_rdata[31:16] == 16'h0));

  a_r4_bad_size_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && !ok_sz) |=> rsp_err);

  a_r4_good_size_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !((req_rd || req_wr) && !ok_sz) |=> !rsp_err);

  a_r13_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> $stable(rsp_rdata));
endmodule

bind bridge_cfg_space bridge_cfg_space_chk #(
  .HAS_CAP(HAS_CAP),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_rd   (req_rd),
  .req_wr   (req_wr),
  .req_addr (req_addr),
  .req_size (req_size),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err)
);

// File: tb/tb_bridge_cfg_space.sv
module tb_bridge_cfg_space;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDW = 32'hC0DE_1AB5;

  logic        clk, rst_n;
  logic        req_rd, req_wr, ev_valid;
  logic [7:0]  req_addr;
  logic [2:0]  req_size;
  logic [31:0] req_wdata, ev_bits;
  logic [5:0]  ev_idx;
  logic [31:0] rd_a, rd_b;
  logic        er_a, er_b;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    bit          sel_b;
    logic [31:0] exp_d;
    logic        exp_e;
    string       tag;
  } item_t;
  item_t sb[$];

  bridge_cfg_space #(.HAS_CAP(1'b1), .NO_PREF(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_bits(ev_bits),
    .rsp_rdata(rd_a), .rsp_err(er_a));

  bridge_cfg_space #(.HAS_CAP(1'b0), .NO_PREF(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_bits(ev_bits),
    .rsp_rdata(rd_b), .rsp_err(er_b));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic idle_inputs();
    req_rd = 0; req_wr = 0; ev_valid = 0;
    req_addr = '0; req_size = 3'd4; req_wdata = '0; ev_idx = '0; ev_bits = '0;
  endtask

  task automatic rd(input bit sel_b, input logic [7:0] a, input logic [2:0] sz,
                    input logic [31:0] exp_d, input logic exp_e, input string tag);
    item_t it;
    @(negedge clk);
    req_rd = 1; req_addr = a; req_size = sz;
    it.sel_b = sel_b; it.exp_d = exp_d; it.exp_e = exp_e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    req_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_wr = 1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_wr = 0;
  endtask

  task automatic ev(input logic [5:0] i, input logic [31:0] b);
    @(negedge clk);
    ev_valid = 1; ev_idx = i; ev_bits = b;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic wr_ev(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d,
                       input logic [5:0] i, input logic [31:0] b);
    @(negedge clk);
    req_wr = 1; req_addr = a; req_size = sz; req_wdata = d;
    ev_valid = 1; ev_idx = i; ev_bits = b;
    @(negedge clk);
    req_wr = 0; ev_valid = 0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one response per read strobe, compared in the following cycle
  initial begin
    forever begin
      @(posedge clk);
      if (req_rd) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R13 actual=unexpected_read expected=queued_item");
        end else begin
          item_t it;
          it = sb.pop_front();
          check({it.tag, " data"}, it.sel_b ? rd_b : rd_a, it.exp_d);
          check({it.tag, " err"}, {31'h0, it.sel_b ? er_b : er_a}, {31'h0, it.exp_e});
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R9 reset rdata", rd_a, 32'h0);
    rst_n = 1;

    // R9: reset contents
    rd(0, 8'h00, 3'd4, IDW,          0, "R9 id word");
    rd(0, 8'h08, 3'd4, 32'h0604_0002, 0, "R9 class/rev");
    rd(0, 8'h0C, 3'd4, 32'h0001_0010, 0, "R9 header/cache line");
    rd(0, 8'h04, 3'd4, 32'h0010_0000, 0, "R9 status cap list");
    rd(0, 8'h34, 3'd4, 32'h0000_0040, 0, "R9 cap pointer");
    rd(1, 8'h34, 3'd4, 32'h0000_0000, 0, "R9 cap pointer absent");
    rd(0, 8'h40, 3'd4, 32'h0040_0010, 0, "R9 cap id/port type");

    // R5: read-only dword ignores writes
    wr(8'h00, 3'd4, 32'hFFFF_FFFF);
    rd(0, 8'h00, 3'd4, IDW, 0, "R5 read-only id unchanged");

    // R2: beyond the end
    wr(8'h7C, 3'd4, 32'hFFFF_FFFF);
    rd(0, 8'h7C, 3'd4, 32'h0, 0, "R2 read at 0x7C");
    rd(0, 8'hFC, 3'd4, 32'h0, 0, "R2 read at 0xFC");
    wr(8'h40, 3'd4, 32'hFFFF_FFFF);
    rd(1, 8'h40, 3'd4, 32'h0, 0, "R2 legacy read at 0x40");

    // R4: bad size
    rd(0, 8'h00, 3'd3, 32'h0, 1, "R4 size 3 read");
    wr(8'h18, 3'd0, 32'hFFFF_FFFF);
    rd(0, 8'h18, 3'd4, 32'h0, 0, "R4 size 0 write dropped");

    // R7: command/status
    wr(8'h04, 3'd4, 32'hFFFF_FFFF);
    rd(0, 8'h04, 3'd4, 32'h0010_0147, 0, "R7 command rw bits");
    rd(1, 8'h04, 3'd4, 32'h0010_0147, 0, "R7 legacy command rw bits");

    // R8/R5/R3: bus numbers and byte lanes
    wr(8'h18, 3'd4, 32'hAABB_CCDD);
    rd(0, 8'h18, 3'd4, 32'h00BB_CCDD, 0, "R8 bus numbers, R1 latency zero");
    wr(8'h19, 3'd1, 32'h0000_0055);
    rd(0, 8'h18, 3'd4, 32'h00BB_55DD, 0, "R5 byte lane write");
    rd(0, 8'h1A, 3'd1, 32'h0000_00BB, 0, "R3 byte read");
    rd(0, 8'h19, 3'd2, 32'h0000_BB55, 0, "R3 half read");
    rd(0, 8'h1B, 3'd4, 32'h00BB_55DD, 0, "R3 unaligned dword read");

    // R8: windows
    wr(8'h20, 3'd4, 32'hFFFF_FFFF);
    rd(0, 8'h20, 3'd4, 32'hFFF0_FFF0, 0, "R8 memory window");
    wr(8'h24, 3'd4, 32'hFFFF_FFFF);
    rd(0, 8'h24, 3'd4, 32'hFFF0_FFF0, 0, "R8 prefetch window");
    rd(1, 8'h24, 3'd4, 32'h0000_0000, 0, "R8 prefetch window removed");

    // R10: bridge control with and without capability region
    wr(8'h3C, 3'd4, 32'hFFFF_FFFF);
    ev(6'd15, 32'h0400_0000);
    rd(0, 8'h3C, 3'd4, 32'h004F_00FF, 0, "R10 cap bridge control");
    rd(1, 8'h3C, 3'd4, 32'h0F6F_00FF, 0, "R10 legacy bridge control");
    wr(8'h3E, 3'd2, 32'h0000_0400);
    rd(1, 8'h3C, 3'd4, 32'h0000_00FF, 0, "R10 legacy discard status cleared");
    rd(0, 8'h3C, 3'd4, 32'h0000_00FF, 0, "R10 cap bridge control after write");

    // R12/R6/R1: events and clears on status
    ev(6'd1, 32'hF900_0001);
    rd(0, 8'h04, 3'd4, 32'hF910_0147, 0, "R12 event sets status, R1 non-w1c ignored");
    wr(8'h07, 3'd1, 32'h0000_0008);
    rd(0, 8'h04, 3'd4, 32'hF110_0147, 0, "R6 single bit clear");
    wr_ev(8'h07, 3'd1, 32'h0000_00C0, 6'd1, 32'h8000_0000);
    rd(0, 8'h04, 3'd4, 32'hB110_0147, 0, "R12 set wins over clear");
    wr(8'h07, 3'd1, 32'h0000_00FF);
    rd(0, 8'h04, 3'd4, 32'h0010_0147, 0, "R6 clear all status");

    // R11: capability region
    wr(8'h50, 3'd4, 32'hFFFF_FFFF);
    rd(0, 8'h50, 3'd4, 32'h0000_CEFB, 0, "R11 link control rw");
    ev(6'd20, 32'hFFFF_0000);
    rd(0, 8'h50, 3'd4, 32'hC000_CEFB, 0, "R11 link status event");
    wr_ev(8'h52, 3'd2, 32'h0000_C000, 6'd20, 32'h4000_0000);
    rd(0, 8'h50, 3'd4, 32'h4000_CEFB, 0, "R12 link status set wins");
    ev(6'd24, 32'h0003_0000);
    rd(0, 8'h60, 3'd4, 32'h0001_0000, 0, "R11 root status bit16 set, bit17 ro");
    wr(8'h60, 3'd4, 32'hFFFF_FFFF);
    rd(0, 8'h60, 3'd4, 32'h0000_0000, 0, "R11 root status cleared");

    // R13: data holds without a read
    rd(0, 8'h08, 3'd4, 32'h0604_0002, 0, "R13 read latency");
    repeat (3) @(negedge clk);
    check("R13 hold after read", rd_a, 32'h0604_0002);

    repeat (3) @(negedge clk);
    check("R13 scoreboard drained", sb.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule